// File: doc/BRIEF.md
# Column Latency and Burst Window Tracker

This block is the timing core that sits beside a DDR3-style command scheduler. It holds the programmed CAS latency, the write delay and a selector for the additive latency, and from them derives the read latency and write latency the scheduler needs. For every read or write column command it accepts, it raises a data-valid window (reads) or a data-enable window (writes) on the correct later clock cycle. A full burst is 8 beats at two beats per clock, so the window is 4 clocks long. A burst-chop request that comes with the command shrinks the window to 2 clocks.

The block also protects the shared data bus and the calibration period. A chopped burst still owns the full 4-clock bus slot, so column commands that follow it are held off until that slot is free. A ZQ calibration command blocks every command for a blackout whose length depends on the calibration context. An illegal configuration raises a flag, and while it is raised the block accepts no command. Requests that come in while the block is busy or flagged are dropped. The scheduler sees this on `cmd_block` and `cfg_err` and presents the request again later.

Top module: `ddr_burst_timer`

## Requirements
- R1: While reset is asserted, and after it is released until the first command, `rd_valid`, `wr_en` and `cmd_block` are low.
- R2: `rd_lat` equals AL + CL. `cfg_al_sel` encodes AL as 0 → 0, 1 → CL-1 and 2 → CL-2.
- R3: `wr_lat` equals AL + CWL, where CWL is `cfg_cwl`.
- R4: `cfg_err` is high when `cfg_al_sel` is 3, when CL is outside 5..11 or when CWL is outside 5..12. While it is high, all command requests are ignored: no window opens and `cmd_block` stays low.
- R5: An accepted read in cycle 0 drives `rd_valid` high in cycles RL to RL+3.
- R6: An accepted write in cycle 0 drives `wr_en` high in cycles WL to WL+3.
- R7: With `chop_req` high alongside the command, the window starts in the same cycle but lasts 2 cycles.
- R8: After an accepted read or write, chopped or not, `cmd_block` is high for the next 3 cycles, and requests in those cycles are ignored. A request held high is accepted 4 cycles after the previous one, and each accepted command gets its own window.
- R9: After an accepted ZQ command, `cmd_block` is high for the next 512 cycles when `zq_ctx` is 1 (after initialization), 256 when it is 2 (after leaving refresh), and 64 when it is 0 or 3. A read request made during this blackout is ignored.
- R10: When requests arrive together, read wins over write and write wins over ZQ. The losing requests are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cl | input | 4 | CAS latency in cycles |
| cfg_al_sel | input | 2 | Additive latency select: 0 none, 1 CL-1, 2 CL-2, 3 illegal |
| cfg_cwl | input | 4 | Write delay in cycles |
| rd_req | input | 1 | Read column command strobe |
| wr_req | input | 1 | Write column command strobe |
| zq_req | input | 1 | ZQ calibration command strobe |
| chop_req | input | 1 | Burst-chop request sent with a read or write |
| zq_ctx | input | 2 | Calibration context: 1 after init, 2 after refresh exit, else other |
| rd_lat | output | 5 | Derived read latency |
| wr_lat | output | 5 | Derived write latency |
| cfg_err | output | 1 | Illegal configuration flag |
| cmd_block | output | 1 | Commands are held off this cycle |
| rd_valid | output | 1 | Read data-valid window |
| wr_en | output | 1 | Write data-enable window |

## Verification
The bench walks a vector table over all three additive-latency choices, the lowest and highest CAS latencies, and both burst kinds. An off-by-one in the shift insertion would move every window by a cycle, and adding AL in the wrong place would place reads at CL alone. It sends a chopped read with a second read held against it. A design that let chopping free the slot early would accept the second read too soon, and a design that did not block would merge the two windows. The three blackout lengths are counted, as is the reserved context, and a read is offered in the middle of a blackout. It also drives the illegal settings and simultaneous requests, where a wrong gate would open windows under a bad setting or let the write win.

// File: rtl/ddrt_pkg.sv
`timescale 1ns/1ps
package ddrt_pkg;
  typedef enum logic [1:0] {
    AL_ZERO  = 2'd0,
    AL_CL_M1 = 2'd1,
    AL_CL_M2 = 2'd2,
    AL_BAD   = 2'd3
  } al_mode_e;

  typedef enum logic [1:0] {
    ZQ_OTHER = 2'd0,
    ZQ_INIT  = 2'd1,
    ZQ_REFX  = 2'd2,
    ZQ_RSVD  = 2'd3
  } zq_ctx_e;
endpackage

// File: rtl/ddrt_lat_calc.sv
`timescale 1ns/1ps
module ddrt_lat_calc #(
  parameter int CFG_W   = 4,
  parameter int LAT_W   = 5,
  parameter int CL_MIN  = 5,
  parameter int CL_MAX  = 11,
  parameter int CWL_MIN = 5,
  parameter int CWL_MAX = 12
) (
  input  logic [CFG_W-1:0] cl,
  input  logic [1:0]       al_sel,
  input  logic [CFG_W-1:0] cwl,
  output logic [LAT_W-1:0] rd_lat,
  output logic [LAT_W-1:0] wr_lat,
  output logic             bad
);
  import ddrt_pkg::*;

  localparam logic [CFG_W-1:0] CL_LO  = CFG_W'(CL_MIN);
  localparam logic [CFG_W-1:0] CL_HI  = CFG_W'(CL_MAX);
  localparam logic [CFG_W-1:0] CWL_LO = CFG_W'(CWL_MIN);
  localparam logic [CFG_W-1:0] CWL_HI = CFG_W'(CWL_MAX);

  logic [LAT_W-1:0] cl_x, cwl_x, al_x;
  logic             al_bad, cl_bad, cwl_bad;

  always_comb begin
    cl_x   = LAT_W'(cl);
    cwl_x  = LAT_W'(cwl);
    al_bad = 1'b0;
    unique case (al_mode_e'(al_sel))
      AL_ZERO:  al_x = '0;
      AL_CL_M1: al_x = cl_x - LAT_W'(1);
      AL_CL_M2: al_x = cl_x - LAT_W'(2);
      default: begin
        al_x   = '0;
        al_bad = 1'b1;
      end
    endcase
    cl_bad  = (cl < CL_LO) || (cl > CL_HI);
    cwl_bad = (cwl < CWL_LO) || (cwl > CWL_HI);
    bad     = al_bad || cl_bad || cwl_bad;
    rd_lat  = al_x + cl_x;
    wr_lat  = al_x + cwl_x;
  end
endmodule

// File: rtl/ddrt_hold_timer.sv
`timescale 1ns/1ps
module ddrt_hold_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             busy
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign busy   = (cnt_q != '0);
  assign cnt_en = load || busy;

  always_comb begin
    if (load) cnt_d = len;
    else      cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R8 / R9: a new hold may only start once the previous one has run out
  p_load_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);

  // R9: a running hold counts down by one each cycle
  p_countdown_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/ddrt_win_pipe.sv
`timescale 1ns/1ps
module ddrt_win_pipe #(
  parameter int DEPTH      = 26,
  parameter int LAT_W      = 5,
  parameter int BURST_CLKS = 4,
  parameter int CHOP_CLKS  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             chop,
  input  logic [LAT_W-1:0] lat,
  output logic             win
);
  localparam logic [DEPTH-1:0] FULL_MASK = {{(DEPTH-BURST_CLKS){1'b0}}, {BURST_CLKS{1'b1}}};
  localparam logic [DEPTH-1:0] CHOP_MASK = {{(DEPTH-CHOP_CLKS){1'b0}}, {CHOP_CLKS{1'b1}}};

  logic [DEPTH-1:0] sr_q, sr_d, ins;

  always_comb begin
    ins = '0;
    if (start) ins = (chop ? CHOP_MASK : FULL_MASK) << (lat - LAT_W'(1));
    sr_d = (sr_q >> 1) | ins;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign win = sr_q[0];

  // R8: a new window never lands on one already in flight
  p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (((sr_q >> 1) & ins) == '0));
endmodule

// File: rtl/ddr_burst_timer.sv
`timescale 1ns/1ps
module ddr_burst_timer #(
  parameter int CFG_W         = 4,
  parameter int CL_MIN        = 5,
  parameter int CL_MAX        = 11,
  parameter int CWL_MIN       = 5,
  parameter int CWL_MAX       = 12,
  parameter int BURST_CLKS    = 4,
  parameter int CHOP_CLKS     = 2,
  parameter int ZQ_INIT_CLKS  = 512,
  parameter int ZQ_REFX_CLKS  = 256,
  parameter int ZQ_SHORT_CLKS = 64,
  localparam int LAT_MAX      = (CL_MAX - 1) + ((CL_MAX > CWL_MAX) ? CL_MAX : CWL_MAX),
  localparam int LAT_W        = $clog2(LAT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_cl,
  input  logic [1:0]       cfg_al_sel,
  input  logic [CFG_W-1:0] cfg_cwl,
  input  logic             rd_req,
  input  logic             wr_req,
  input  logic             zq_req,
  input  logic             chop_req,
  input  logic [1:0]       zq_ctx,
  output logic [LAT_W-1:0] rd_lat,
  output logic [LAT_W-1:0] wr_lat,
  output logic             cfg_err,
  output logic             cmd_block,
  output logic             rd_valid,
  output logic             wr_en
);
  import ddrt_pkg::*;

  localparam int DEPTH  = LAT_MAX + BURST_CLKS;
  localparam int SLOT_W = $clog2(BURST_CLKS);
  localparam int ZQ_W   = $clog2(ZQ_INIT_CLKS + 1);

  // reset: asserted at once, released on a clock edge
  logic [1:0] rst_sq;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= 2'b00;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_i_n = rst_sq[1];

  ddrt_lat_calc #(
    .CFG_W(CFG_W), .LAT_W(LAT_W), .CL_MIN(CL_MIN), .CL_MAX(CL_MAX),
    .CWL_MIN(CWL_MIN), .CWL_MAX(CWL_MAX)
  ) u_lat (
    .cl(cfg_cl), .al_sel(cfg_al_sel), .cwl(cfg_cwl),
    .rd_lat(rd_lat), .wr_lat(wr_lat), .bad(cfg_err)
  );

  // command acceptance with fixed priority read > write > ZQ
  logic slot_busy, zq_busy, can_issue;
  logic acc_rd, acc_wr, acc_zq, acc_col;
  logic [ZQ_W-1:0] zq_len;

  always_comb begin
    cmd_block = slot_busy || zq_busy;
    can_issue = !cmd_block && !cfg_err;
    acc_rd    = can_issue && rd_req;
    acc_wr    = can_issue && wr_req && !rd_req;
    acc_zq    = can_issue && zq_req && !rd_req && !wr_req;
    acc_col   = acc_rd || acc_wr;
    unique case (zq_ctx_e'(zq_ctx))
      ZQ_INIT: zq_len = ZQ_W'(ZQ_INIT_CLKS);
      ZQ_REFX: zq_len = ZQ_W'(ZQ_REFX_CLKS);
      default: zq_len = ZQ_W'(ZQ_SHORT_CLKS);
    endcase
  end

  ddrt_hold_timer #(.CNT_W(SLOT_W)) u_slot (
    .clk(clk), .rst_n(rst_i_n), .load(acc_col),
    .len(SLOT_W'(BURST_CLKS - 1)), .busy(slot_busy)
  );

  ddrt_hold_timer #(.CNT_W(ZQ_W)) u_zq (
    .clk(clk), .rst_n(rst_i_n), .load(acc_zq),
    .len(zq_len), .busy(zq_busy)
  );

  ddrt_win_pipe #(
    .DEPTH(DEPTH), .LAT_W(LAT_W), .BURST_CLKS(BURST_CLKS), .CHOP_CLKS(CHOP_CLKS)
  ) u_rdwin (
    .clk(clk), .rst_n(rst_i_n), .start(acc_rd), .chop(chop_req),
    .lat(rd_lat), .win(rd_valid)
  );

  ddrt_win_pipe #(
    .DEPTH(DEPTH), .LAT_W(LAT_W), .BURST_CLKS(BURST_CLKS), .CHOP_CLKS(CHOP_CLKS)
  ) u_wrwin (
    .clk(clk), .rst_n(rst_i_n), .start(acc_wr), .chop(chop_req),
    .lat(wr_lat), .win(wr_en)
  );

  // R8: an accepted column command holds off the next cycle
  p_slot_block_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    acc_col |=> cmd_block);

  // R9: an accepted calibration command holds off the next cycle
  p_zq_block_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    acc_zq |=> (cmd_block && zq_busy));
endmodule

// File: tb/tb_ddr_burst_timer.sv
`timescale 1ns/1ps
module tb_ddr_burst_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] cfg_cl = 4'd5, cfg_cwl = 4'd5;
  logic [1:0] cfg_al_sel = 2'd0, zq_ctx = 2'd0;
  logic       rd_req = 1'b0, wr_req = 1'b0, zq_req = 1'b0, chop_req = 1'b0;
  logic [4:0] rd_lat, wr_lat;
  logic       cfg_err, cmd_block, rd_valid, wr_en;

  int checks = 0;
  int errors = 0;
  logic [63:0] rdv, wrv, blk;

  always #10 clk = ~clk;  // 50 MHz

  ddr_burst_timer dut (
    .clk(clk), .rst_n(rst_n), .cfg_cl(cfg_cl), .cfg_al_sel(cfg_al_sel),
    .cfg_cwl(cfg_cwl), .rd_req(rd_req), .wr_req(wr_req), .zq_req(zq_req),
    .chop_req(chop_req), .zq_ctx(zq_ctx), .rd_lat(rd_lat), .wr_lat(wr_lat),
    .cfg_err(cfg_err), .cmd_block(cmd_block), .rd_valid(rd_valid), .wr_en(wr_en)
  );

  // cl, al_sel, cwl, is_write, chop, exp_rl, exp_wl, exp_start, exp_len
  localparam int NVEC = 8;
  localparam int VEC [NVEC][9] = '{
    '{ 5, 0,  5, 0, 0,  5,  5,  5, 4},
    '{11, 1, 12, 0, 0, 21, 22, 21, 4},
    '{ 7, 2,  6, 0, 1, 12, 11, 12, 2},
    '{ 6, 0,  8, 1, 0,  6,  8,  8, 4},
    '{ 9, 1,  7, 1, 1, 17, 15, 15, 2},
    '{11, 2, 12, 1, 0, 20, 21, 21, 4},
    '{ 8, 0,  6, 0, 1,  8,  6,  8, 2},
    '{10, 2,  6, 1, 0, 18, 14, 14, 4}
  };

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] win_mask(int s, int n);
    return ((64'd1 << n) - 64'd1) << s;
  endfunction

  task automatic set_cfg(int cl, int al, int cwl);
    @(negedge clk);
    cfg_cl = 4'(cl); cfg_al_sel = 2'(al); cfg_cwl = 4'(cwl);
  endtask

  // request in cycle 0; returns at the negedge of cycle 1
  task automatic issue(bit r, bit w, bit z, bit c, int ctx);
    @(negedge clk);
    rd_req = r; wr_req = w; zq_req = z; chop_req = c; zq_ctx = 2'(ctx);
    @(negedge clk);
    rd_req = 1'b0; wr_req = 1'b0; zq_req = 1'b0; chop_req = 1'b0;
  endtask

  // bit k holds the output seen in cycle k after the command
  task automatic capture(int n);
    rdv = '0; wrv = '0; blk = '0;
    for (int k = 1; k <= n; k++) begin
      rdv[k] = rd_valid; wrv[k] = wr_en; blk[k] = cmd_block;
      if (k < n) @(negedge clk);
    end
  endtask

  task automatic drain();
    repeat (30) @(negedge clk);
  endtask

  task automatic zq_run(int ctx, int exp_len);
    int cnt = 0;
    issue(1'b0, 1'b0, 1'b1, 1'b0, ctx);
    while (cmd_block && cnt < 700) begin
      cnt++;
      @(negedge clk);
    end
    check(cnt == exp_len, "R9", $sformatf("blackout length ctx %0d", ctx), cnt, exp_len);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] exp;
    // R1: outputs quiet in and just after reset
    repeat (3) @(negedge clk);
    check({rd_valid, wr_en, cmd_block} == 3'b000, "R1", "outputs during reset",
          {rd_valid, wr_en, cmd_block}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({rd_valid, wr_en, cmd_block} == 3'b000, "R1", "outputs after reset",
          {rd_valid, wr_en, cmd_block}, 0);

    // table: latency derivation and window placement
    for (int v = 0; v < NVEC; v++) begin
      set_cfg(VEC[v][0], VEC[v][1], VEC[v][2]);
      @(negedge clk);
      check(cfg_err == 1'b0, "R4", $sformatf("vec %0d legal config", v), cfg_err, 0);
      check(rd_lat == 5'(VEC[v][5]), "R2", $sformatf("vec %0d rd_lat", v), rd_lat, VEC[v][5]);
      check(wr_lat == 5'(VEC[v][6]), "R3", $sformatf("vec %0d wr_lat", v), wr_lat, VEC[v][6]);
      issue(VEC[v][3] == 0, VEC[v][3] == 1, 1'b0, VEC[v][4] == 1, 0);
      capture(40);
      exp = win_mask(VEC[v][7], VEC[v][8]);
      if (VEC[v][3] == 1) begin
        check(wrv == exp, (VEC[v][4] == 1) ? "R7" : "R6", $sformatf("vec %0d write window", v), wrv, exp);
        check(rdv == 0, "R6", $sformatf("vec %0d no read window", v), rdv, 0);
      end else begin
        check(rdv == exp, (VEC[v][4] == 1) ? "R7" : "R5", $sformatf("vec %0d read window", v), rdv, exp);
        check(wrv == 0, "R5", $sformatf("vec %0d no write window", v), wrv, 0);
      end
      check(blk == win_mask(1, 3), "R8", $sformatf("vec %0d slot hold", v), blk, win_mask(1, 3));
      drain();
    end

    // R8: chopped read then a held read, accepted four cycles later
    set_cfg(5, 0, 5);
    @(negedge clk);
    rd_req = 1'b1; chop_req = 1'b1;
    rdv = '0; blk = '0;
    for (int k = 1; k <= 30; k++) begin
      @(negedge clk);
      rdv[k] = rd_valid; blk[k] = cmd_block;
      if (k == 1) chop_req = 1'b0;
      if (k == 5) rd_req = 1'b0;
    end
    exp = win_mask(5, 2) | win_mask(9, 4);
    check(rdv == exp, "R8", "back-to-back read windows", rdv, exp);
    exp = win_mask(1, 3) | win_mask(5, 3);
    check(blk == exp, "R8", "back-to-back slot holds", blk, exp);
    drain();

    // R10: read beats write; write beats ZQ
    set_cfg(5, 0, 8);
    issue(1'b1, 1'b1, 1'b0, 1'b0, 0);
    capture(40);
    check(rdv == win_mask(5, 4), "R10", "read wins over write", rdv, win_mask(5, 4));
    check(wrv == 0, "R10", "write dropped", wrv, 0);
    drain();
    issue(1'b0, 1'b1, 1'b1, 1'b0, 1);
    capture(40);
    check(wrv == win_mask(8, 4), "R10", "write wins over ZQ", wrv, win_mask(8, 4));
    check(blk == win_mask(1, 3), "R10", "ZQ dropped, slot hold only", blk, win_mask(1, 3));
    drain();

    // R4: illegal settings flag and swallow requests
    set_cfg(5, 3, 5);
    @(negedge clk);
    check(cfg_err == 1'b1, "R4", "al_sel 3 flagged", cfg_err, 1);
    issue(1'b1, 1'b0, 1'b0, 1'b0, 0);
    capture(30);
    check(rdv == 0 && blk == 0, "R4", "read ignored under bad config", rdv | blk, 0);
    set_cfg(4, 0, 5);
    @(negedge clk);
    check(cfg_err == 1'b1, "R4", "CL 4 flagged", cfg_err, 1);
    set_cfg(12, 0, 5);
    @(negedge clk);
    check(cfg_err == 1'b1, "R4", "CL 12 flagged", cfg_err, 1);
    set_cfg(6, 0, 4);
    @(negedge clk);
    check(cfg_err == 1'b1, "R4", "CWL 4 flagged", cfg_err, 1);
    issue(1'b0, 1'b1, 1'b0, 1'b0, 0);
    capture(30);
    check(wrv == 0 && blk == 0, "R4", "write ignored under bad config", wrv | blk, 0);
    set_cfg(6, 0, 13);
    @(negedge clk);
    check(cfg_err == 1'b1, "R4", "CWL 13 flagged", cfg_err, 1);

    // R9: blackout lengths per context
    set_cfg(5, 0, 5);
    zq_run(1, 512);
    zq_run(2, 256);
    zq_run(0, 64);
    zq_run(3, 64);

    // R9: read offered during a blackout is dropped
    issue(1'b0, 1'b0, 1'b1, 1'b0, 0);
    repeat (9) @(negedge clk);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    capture(40);
    check(rdv == 0, "R9", "read ignored during blackout", rdv, 0);
    repeat (40) @(negedge clk);
    check(cmd_block == 1'b0, "R9", "blackout over", cmd_block, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule